// File: doc/BRIEF.md
# Antenna Diversity Switch Controller

This block steers an external two-way RF switch that sits between two receive antennas and a packet radio. While the receiver is listening and diversity is enabled, it alternates between the antennas on a fixed dwell time. Hardware outside this block evaluates signal quality and detects the synchronization header. When that detector fires, the controller freezes on the antenna in use. It also records that antenna in a status bit that software can read, for example to pick a matching transmit antenna.

The status bit changes only at a header lock. When a frame ends, the switch goes back to alternating, but the status bit keeps reporting the antenna of the last received frame until the next lock. The antenna used for transmit, or for a fixed manual setting, comes from a 2-bit software field. It never comes from the receive selection. The two switch outputs are complementary and are driven only when the external-switch enable is set.

Top module: `ant_div_ctrl`

## Requirements
- R1: During reset and on the first clock after it, `ant_status`, `sw_p` and `sw_n` are 0. With `ext_sw_en`=1 and `div_en`=0 after reset, antenna 0 is applied (`sw_p`=0, `sw_n`=1).
- R2: With `ext_sw_en`=1, `sw_p` is 1 for antenna 1 and 0 for antenna 0, and `sw_n` is always the complement of `sw_p`. Both outputs are registered and follow the applied antenna one clock later.
- R3: With `ext_sw_en`=0, `sw_p` and `sw_n` are both 0 from the next clock.
- R4: `ant_ctrl`=01 selects antenna 0 and `ant_ctrl`=10 selects antenna 1. The values 00 and 11 keep the last manual antenna. A new value reaches the switch outputs two clocks after it is sampled.
- R5: With `div_en`=0, the manual antenna is applied permanently and the switch never toggles on its own.
- R6: With `div_en`=1, `rx_state` in a listening state (01 = listen, 10 = listen with auto-acknowledge) and no lock held, the antenna toggles every DWELL clocks (default 16).
- R7: In the other receiver states (00 = off, 11 = busy), the search antenna holds and the dwell count restarts.
- R8: A `hdr_det` strobe while `div_en`=1 and listening locks the search on the current antenna. The switch then holds until the lock is released.
- R9: `ant_status` is loaded only on a header lock, with the antenna current at that edge. It keeps that value across frame end and the resumed search.
- R10: A `frame_done` strobe releases the lock at the next clock, and the search first toggles DWELL clocks after the release. If `hdr_det` and `frame_done` arrive in the same cycle, the header wins and the lock stays.
- R11: A `hdr_det` strobe while `rx_state` is not a listening state is ignored. No lock is taken and `ant_status` is unchanged.
- R12: While `tx_active`=1, the manual antenna from `ant_ctrl` is applied regardless of the search antenna and of `ant_status`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| div_en | input | 1 | Enables the automatic antenna search |
| ext_sw_en | input | 1 | Enables driving of the external switch outputs |
| ant_ctrl | input | 2 | Manual antenna field (01 = ant 0, 10 = ant 1, else hold) |
| rx_state | input | 2 | Receiver state: 00 off, 01 listen, 10 listen with auto-ack, 11 busy |
| hdr_det | input | 1 | Synchronization header detected strobe |
| frame_done | input | 1 | Frame reception complete strobe |
| tx_active | input | 1 | Transmitter active |
| ant_status | output | 1 | Antenna of the last header lock |
| sw_p | output | 1 | Switch control (1 = antenna 1) |
| sw_n | output | 1 | Complement of sw_p |

## Verification
The header strobe and the frame-done strobe can arrive in the same clock. In that cycle, one of them takes a lock and the other drops it. The bench pulses both together while a lock is held. It expects the lock to survive: the switch stays frozen for three dwell periods and `ant_status` is reloaded. A lone frame-done pulse is then checked to bring the first toggle exactly DWELL+1 sampled cycles later. A second overlap is transmit against search: `tx_active` is raised during a lock whose antenna differs from the manual field, and the switch must show the manual antenna while `ant_status` stays put.

// File: rtl/ant_div_pkg.sv
package ant_div_pkg;

  // Receiver state encoding seen on rx_state
  typedef enum logic [1:0] {
    RXS_OFF       = 2'b00,
    RXS_LISTEN    = 2'b01,
    RXS_LISTEN_AK = 2'b10,
    RXS_BUSY      = 2'b11
  } rxs_e;

  // Manual antenna field codes
  localparam logic [1:0] MAN_SEL_A0 = 2'b01;
  localparam logic [1:0] MAN_SEL_A1 = 2'b10;

  function automatic logic rxs_listening(input logic [1:0] st);
    return (rxs_e'(st) == RXS_LISTEN) || (rxs_e'(st) == RXS_LISTEN_AK);
  endfunction

endpackage

// File: rtl/ant_div_search.sv
module ant_div_search #(
  parameter int DWELL = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic div_en,
  input  logic listening,
  input  logic hdr_det,
  input  logic frame_done,
  output logic search_ant,
  output logic locked,
  output logic status
);
  localparam int CW = (DWELL > 1) ? $clog2(DWELL) : 1;
  localparam logic [CW-1:0] LAST = CW'(DWELL - 1);

  logic [CW-1:0] dwell_cnt;
  logic          ant_q;
  logic          lock_q;
  logic          stat_q;
  logic          hdr_take;
  logic          run;

  assign hdr_take = div_en && listening && hdr_det;
  assign run      = div_en && listening && !lock_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dwell_cnt <= '0;
      ant_q     <= 1'b0;
      lock_q    <= 1'b0;
      stat_q    <= 1'b0;
    end else if (!div_en) begin
      dwell_cnt <= '0;
      lock_q    <= 1'b0;
    end else begin
      // lock and release: header wins over frame end
      if (hdr_take) begin
        lock_q <= 1'b1;
        stat_q <= ant_q;
      end else if (frame_done) begin
        lock_q <= 1'b0;
      end
      // dwell timer and toggling
      if (hdr_take || !run) begin
        dwell_cnt <= '0;
      end else if (dwell_cnt == LAST) begin
        dwell_cnt <= '0;
        ant_q     <= ~ant_q;
      end else begin
        dwell_cnt <= dwell_cnt + 1'b1;
      end
    end
  end

  assign search_ant = ant_q;
  assign locked     = lock_q;
  assign status     = stat_q;

  // R6: dwell counter never passes its last value
  a_r6_dwell_bound: assert property (@(posedge clk) disable iff (rst)
    dwell_cnt <= LAST);

  // R8: a held lock freezes the search antenna
  a_r8_lock_freezes: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> $stable(ant_q));

  // R9: status only moves after a header strobe
  a_r9_status_on_hdr: assert property (@(posedge clk) disable iff (rst)
    !$stable(stat_q) |-> $past(hdr_det));

  // R10: lone frame end with diversity on releases the lock
  a_r10_release: assert property (@(posedge clk) disable iff (rst)
    lock_q && frame_done && !hdr_det |=> !lock_q);

  // R10: simultaneous header and frame end keeps the lock
  a_r10_hdr_wins: assert property (@(posedge clk) disable iff (rst)
    div_en && listening && hdr_det && frame_done |=> lock_q);

  // R11: header outside listening takes no lock
  a_r11_ignore: assert property (@(posedge clk) disable iff (rst)
    !lock_q && hdr_det && !listening |=> !lock_q);

endmodule

// File: rtl/ant_div_manual.sv
module ant_div_manual
  import ant_div_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] ant_ctrl,
  output logic       man_ant
);
  logic man_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      man_q <= 1'b0;
    end else begin
      case (ant_ctrl)
        MAN_SEL_A0: man_q <= 1'b0;
        MAN_SEL_A1: man_q <= 1'b1;
        default:    man_q <= man_q;
      endcase
    end
  end

  assign man_ant = man_q;

  // R4: undefined codes hold the manual antenna
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (ant_ctrl == 2'b00 || ant_ctrl == 2'b11) |=> $stable(man_q));

  // R4: code 10 picks antenna 1
  a_r4_sel1: assert property (@(posedge clk) disable iff (rst)
    ant_ctrl == 2'b10 |=> man_q);

endmodule

// File: rtl/ant_div_drive.sv
module ant_div_drive (
  input  logic clk,
  input  logic rst,
  input  logic ext_sw_en,
  input  logic div_en,
  input  logic tx_active,
  input  logic search_ant,
  input  logic man_ant,
  output logic sw_p,
  output logic sw_n
);
  logic applied;
  logic p_q;
  logic n_q;

  assign applied = (div_en && !tx_active) ? search_ant : man_ant;

  always_ff @(posedge clk) begin
    if (rst) begin
      p_q <= 1'b0;
      n_q <= 1'b0;
    end else if (ext_sw_en) begin
      p_q <= applied;
      n_q <= ~applied;
    end else begin
      p_q <= 1'b0;
      n_q <= 1'b0;
    end
  end

  assign sw_p = p_q;
  assign sw_n = n_q;

  // R3: outputs parked low when the switch is disabled
  a_r3_off_low: assert property (@(posedge clk) disable iff (rst)
    !ext_sw_en |=> !p_q && !n_q);

  // R2: enabled outputs are complementary
  a_r2_complement: assert property (@(posedge clk) disable iff (rst)
    ext_sw_en |=> p_q != n_q);

  // R12: transmit uses the manual antenna
  a_r12_tx_manual: assert property (@(posedge clk) disable iff (rst)
    ext_sw_en && tx_active |=> p_q == $past(man_ant));

endmodule

// File: rtl/ant_div_ctrl.sv
module ant_div_ctrl
  import ant_div_pkg::*;
#(
  parameter int DWELL = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       div_en,
  input  logic       ext_sw_en,
  input  logic [1:0] ant_ctrl,
  input  logic [1:0] rx_state,
  input  logic       hdr_det,
  input  logic       frame_done,
  input  logic       tx_active,
  output logic       ant_status,
  output logic       sw_p,
  output logic       sw_n
);
  logic listening;
  logic search_ant;
  logic locked;
  logic man_ant;

  assign listening = rxs_listening(rx_state);

  ant_div_search #(.DWELL(DWELL)) u_search (
    .clk        (clk),
    .rst        (rst),
    .div_en     (div_en),
    .listening  (listening),
    .hdr_det    (hdr_det),
    .frame_done (frame_done),
    .search_ant (search_ant),
    .locked     (locked),
    .status     (ant_status)
  );

  ant_div_manual u_manual (
    .clk      (clk),
    .rst      (rst),
    .ant_ctrl (ant_ctrl),
    .man_ant  (man_ant)
  );

  ant_div_drive u_drive (
    .clk        (clk),
    .rst        (rst),
    .ext_sw_en  (ext_sw_en),
    .div_en     (div_en),
    .tx_active  (tx_active),
    .search_ant (search_ant),
    .man_ant    (man_ant),
    .sw_p       (sw_p),
    .sw_n       (sw_n)
  );

  // R1: first cycle out of reset shows cleared outputs
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !ant_status && !sw_p && !sw_n);

  // R5: with diversity off and the manual field holding, the switch stays put
  a_r5_no_auto: assert property (@(posedge clk) disable iff (rst)
    !div_en && $past(!div_en) && ext_sw_en && $past(ext_sw_en)
      && $past(ant_ctrl == 2'b00 || ant_ctrl == 2'b11) && (ant_ctrl == 2'b00 || ant_ctrl == 2'b11)
      |=> $stable(sw_p));

  // R8: no search toggling while a lock is held
  a_r8_locked_still: assert property (@(posedge clk) disable iff (rst)
    locked |=> $stable(search_ant));

endmodule

// File: tb/ant_div_ctrl_bench.sv
`timescale 1ns/1ps
module ant_div_ctrl_bench;
  localparam int DWELL = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst = 1'b1;
  logic       div_en = 1'b0;
  logic       ext_sw_en = 1'b0;
  logic [1:0] ant_ctrl = 2'b00;
  logic [1:0] rx_state = 2'b00;
  logic       hdr_det = 1'b0;
  logic       frame_done = 1'b0;
  logic       tx_active = 1'b0;
  logic       ant_status, sw_p, sw_n;

  ant_div_ctrl #(.DWELL(DWELL)) u_ant_div_ctrl (
    .clk(clk), .rst(rst), .div_en(div_en), .ext_sw_en(ext_sw_en),
    .ant_ctrl(ant_ctrl), .rx_state(rx_state), .hdr_det(hdr_det),
    .frame_done(frame_done), .tx_active(tx_active),
    .ant_status(ant_status), .sw_p(sw_p), .sw_n(sw_n)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    due;
    string tag;
    bit    chk_sw;
    logic  p;
    logic  n;
    bit    chk_st;
    logic  s;
  } exp_t;
  exp_t q[$];

  // driver side: expectation for the outputs after the next rising edge
  task automatic expect_out(string tag, bit csw, logic p, logic n, bit cst, logic s);
    exp_t e;
    e.due = cyc + 1; e.tag = tag; e.chk_sw = csw; e.p = p; e.n = n;
    e.chk_st = cst; e.s = s;
    q.push_back(e);
    @(negedge clk);
  endtask

  // monitor side
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      if (e.chk_sw) begin
        checks++;
        if (sw_p !== e.p || sw_n !== e.n) begin
          errors++;
          $display("FAIL %s: sw_p/sw_n=%b%b expected %b%b", e.tag, sw_p, sw_n, e.p, e.n);
        end
      end
      if (e.chk_st) begin
        checks++;
        if (ant_status !== e.s) begin
          errors++;
          $display("FAIL %s: ant_status=%b expected %b", e.tag, ant_status, e.s);
        end
      end
    end
  end

  task automatic direct(string tag, int act, int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp_v);
    end
  endtask

  // count sampled cycles until sw_p changes, bounded by limit
  task automatic wait_toggle(output int n, input int limit);
    logic start;
    start = sw_p;
    n = 0;
    while (sw_p == start && n < limit) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic settle(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic summary;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end

  initial begin
    int n;
    settle(3);
    // R1: reset state
    expect_out("R1 in reset", 1, 0, 0, 1, 0);
    ext_sw_en = 1'b1;
    expect_out("R1 reset overrides enable", 1, 0, 0, 1, 0);
    rst = 1'b0;
    expect_out("R1 antenna 0 after reset", 1, 0, 1, 1, 0);

    // R4 / R2: manual field
    ant_ctrl = 2'b10; settle(1);
    expect_out("R4 code 10 -> ant1", 1, 1, 0, 0, 0);
    ant_ctrl = 2'b11; settle(3);
    expect_out("R4 code 11 holds", 1, 1, 0, 0, 0);
    ant_ctrl = 2'b01; settle(1);
    expect_out("R2 ant0 complement", 1, 0, 1, 0, 0);
    ant_ctrl = 2'b00; settle(3);
    expect_out("R4 code 00 holds", 1, 0, 1, 0, 0);

    // R3: switch disabled
    ext_sw_en = 1'b0;
    expect_out("R3 disabled low", 1, 0, 0, 0, 0);
    ext_sw_en = 1'b1;
    expect_out("R3 re-enabled", 1, 0, 1, 0, 0);

    // R5: diversity off while listening
    rx_state = 2'b01; ant_ctrl = 2'b10; settle(1);
    expect_out("R5 manual ant1", 1, 1, 0, 0, 0);
    wait_toggle(n, 3*DWELL);
    direct("R5 no auto toggle", n, 3*DWELL);
    ant_ctrl = 2'b01; settle(1);
    expect_out("R5 manual ant0", 1, 0, 1, 0, 0);

    // R6: search in plain listen
    div_en = 1'b1;
    wait_toggle(n, 2*DWELL + 4);
    wait_toggle(n, 2*DWELL + 4);
    direct("R6 dwell period listen", n, DWELL);
    direct("R2 complement while searching", sw_n, !sw_p);
    rx_state = 2'b10;
    wait_toggle(n, 2*DWELL + 4);
    wait_toggle(n, 2*DWELL + 4);
    direct("R6 dwell period listen-ack", n, DWELL);

    // R7: non-listening states freeze the search
    rx_state = 2'b11;
    wait_toggle(n, 3*DWELL);
    direct("R7 busy freezes", n, 3*DWELL);
    rx_state = 2'b00;
    wait_toggle(n, 3*DWELL);
    direct("R7 off freezes", n, 3*DWELL);
    rx_state = 2'b01;

    // R8 / R9: lock on antenna 1
    if (sw_p != 1'b1) wait_toggle(n, 2*DWELL + 4);
    settle(4);
    hdr_det = 1'b1;
    expect_out("R8 R9 lock on ant1", 1, 1, 0, 1, 1);
    hdr_det = 1'b0;
    wait_toggle(n, 3*DWELL);
    direct("R8 lock holds switch", n, 3*DWELL);

    // R12: transmit with manual antenna 0 during the lock
    tx_active = 1'b1;
    expect_out("R12 tx uses manual ant0", 1, 0, 1, 1, 1);
    tx_active = 1'b0;
    expect_out("R12 back to locked ant1", 1, 1, 0, 1, 1);

    // R10: header and frame end together, header wins
    hdr_det = 1'b1; frame_done = 1'b1;
    expect_out("R10 simultaneous keeps status", 0, 0, 0, 1, 1);
    hdr_det = 1'b0; frame_done = 1'b0;
    wait_toggle(n, 3*DWELL);
    direct("R10 lock kept on overlap", n, 3*DWELL);

    // R10: lone frame end releases
    frame_done = 1'b1; settle(1); frame_done = 1'b0;
    wait_toggle(n, 3*DWELL);
    direct("R10 first toggle after release", n, DWELL + 1);
    direct("R9 status held after frame", ant_status, 1);

    // R11: header while not listening is ignored
    if (sw_p != 1'b0) wait_toggle(n, 2*DWELL + 4);
    settle(2);
    rx_state = 2'b00;
    hdr_det = 1'b1;
    expect_out("R11 status unchanged", 1, 0, 1, 1, 1);
    hdr_det = 1'b0; rx_state = 2'b01;
    wait_toggle(n, 3*DWELL);
    direct("R11 no lock taken", n, DWELL + 1);
    direct("R9 status still last frame", ant_status, 1);

    settle(2);
    summary();
    $finish;
  end

endmodule